// File: doc/BRIEF.md
# Mode-Selectable Three-Valued Logic Unit

This block applies one of four logic operators (negation, conjunction, disjunction, implication) in parallel across every trit of two W-trit operand words. Each trit is carried on two wires, and every trit lane works on its own, with no carry between lanes.

Which three-valued logic supplies the truth tables is chosen by a stored mode. The mode can be Kleene, Łukasiewicz, Bochvar, Heyting or RM3. By default, negation flips the sign of a trit, conjunction takes the minimum and disjunction takes the maximum. Each logic replaces only the operators that it defines differently. Every logic has its own implication.

The mode register is the block's only state. It behaves as a five-state machine:

| State | Mode code |
|---|---|
| ST_KLEENE | 0 |
| ST_LUKA | 1 |
| ST_BOCHVAR | 2 |
| ST_HEYTING | 3 |
| ST_RM3 | 4 |

The register has four transitions:

- **reset**: any state goes to ST_KLEENE.
- **load**: when write enable is high, the register moves to the state named by the mode code.
- **fallback**: a write with a code from 5 to 7 lands in ST_KLEENE.
- **hold**: with no write, the state stays where it is.

The result word follows the operands, the opcode and the stored mode combinationally.

Top module: `tern_logic_unit`

## Requirements
- R1: Each trit is encoded on 2 bits, with trit i at bits [2i+1:2i]: 2'b00 = Z (0), 2'b01 = P (+1), 2'b11 = N (−1). Code 2'b10 on an input is treated as Z. The output only ever carries 2'b00, 2'b01 or 2'b11.
- R2: The opcode encoding is 0 = NOT (applied to operand a only), 1 = AND, 2 = OR, 3 = IMPLY. Every lane uses only its own trits.
- R3: The default operators are NOT a = −a, AND = min(a,b) and OR = max(a,b). Kleene, Łukasiewicz and RM3 keep the default AND and OR. All modes except Heyting keep the default NOT.
- R4: Kleene implication is max(−a, b), so IMPLY(Z,Z) = Z.
- R5: Łukasiewicz implication is min(+1, 1 − a + b), so IMPLY(Z,Z) = P.
- R6: In Bochvar mode, AND, OR and IMPLY give Z whenever either input is Z. With no Z input they give min, max and max(−a, b).
- R7: In Heyting mode, NOT gives N for P, N for Z and P for N. IMPLY gives P when a ≤ b and gives b otherwise.
- R8: RM3 implication is max(−a, b) when a ≤ b, and min(−a, b) otherwise.
- R9: The mode codes are 0 Kleene, 1 Łukasiewicz, 2 Bochvar, 3 Heyting and 4 RM3. A write with the enable high is captured on the rising clock edge and governs the result from then on.
- R10: A write with a code from 5 to 7 selects Kleene.
- R11: Asynchronous active-low reset selects Kleene. Writes attempted while reset is low have no effect.
- R12: With the write enable low, the stored mode does not change, whatever the mode code input carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_en | input | 1 | Loads mode_code on the rising edge |
| mode_code | input | 3 | Logic selection code |
| op | input | 2 | Operator select |
| a | input | 2*W | Operand word a, W trits |
| b | input | 2*W | Operand word b, W trits |
| y | output | 2*W | Result word, W trits |

## Verification
The result word has no register in its path, so it is due in the same cycle that the operands and opcode are applied. The bench drives these on the falling edge and compares them 1 ns later. A mode write becomes visible only after the rising edge that captures it. Each mode change therefore drives the enable on a falling edge, waits through the next rising edge, and drops the enable on the following falling edge before any operand is applied. The reset and hold checks follow the same edge discipline, so each check observes exactly one stored mode.

// File: rtl/tlu_pkg.sv
`timescale 1ns/1ps
package tlu_pkg;

    localparam logic [1:0] TR_Z = 2'b00;
    localparam logic [1:0] TR_P = 2'b01;
    localparam logic [1:0] TR_N = 2'b11;

    typedef enum logic [2:0] {
        ST_KLEENE  = 3'd0,
        ST_LUKA    = 3'd1,
        ST_BOCHVAR = 3'd2,
        ST_HEYTING = 3'd3,
        ST_RM3     = 3'd4
    } lmode_t;

    typedef enum logic [1:0] {
        OP_NOT = 2'd0,
        OP_AND = 2'd1,
        OP_OR  = 2'd2,
        OP_IMP = 2'd3
    } lop_t;

    // decode a trit to a signed value; the unused code reads as zero
    function automatic logic signed [3:0] trit_val(input logic [1:0] t);
        case (t)
            TR_P:    trit_val = 4'sd1;
            TR_N:    trit_val = -4'sd1;
            default: trit_val = 4'sd0;
        endcase
    endfunction

    function automatic logic [1:0] trit_enc(input logic signed [3:0] v);
        if (v > 4'sd0)      trit_enc = TR_P;
        else if (v < 4'sd0) trit_enc = TR_N;
        else                trit_enc = TR_Z;
    endfunction

    function automatic logic signed [3:0] smin(input logic signed [3:0] x,
                                               input logic signed [3:0] y);
        smin = (x < y) ? x : y;
    endfunction

    function automatic logic signed [3:0] smax(input logic signed [3:0] x,
                                               input logic signed [3:0] y);
        smax = (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/tlu_mode_reg.sv
`timescale 1ns/1ps
module tlu_mode_reg
    import tlu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] code_in,
    output lmode_t     mode_q
);

    lmode_t mode_d;

    // next-state: load, fallback or hold
    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            unique case (code_in)
                3'd0:    mode_d = ST_KLEENE;
                3'd1:    mode_d = ST_LUKA;
                3'd2:    mode_d = ST_BOCHVAR;
                3'd3:    mode_d = ST_HEYTING;
                3'd4:    mode_d = ST_RM3;
                default: mode_d = ST_KLEENE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= ST_KLEENE;
        else        mode_q <= mode_d;
    end

    // R9
    write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && code_in <= 3'd4) |=> (mode_q == lmode_t'($past(code_in))));

    // R10
    fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && code_in > 3'd4) |=> (mode_q == ST_KLEENE));

    // R12
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_q));

    // R11
    reset_mode_chk: assert property (@(posedge clk)
        !rst_n |=> (mode_q == ST_KLEENE));

endmodule

// File: rtl/tlu_trit_cell.sv
`timescale 1ns/1ps
module tlu_trit_cell
    import tlu_pkg::*;
(
    input  lmode_t     mode_i,
    input  lop_t       op_i,
    input  logic [1:0] a_i,
    input  logic [1:0] b_i,
    output logic [1:0] y_o
);

    logic signed [3:0] av, bv, na, lo, hi, luk, res;
    logic              any_z;

    always_comb begin
        av    = trit_val(a_i);
        bv    = trit_val(b_i);
        na    = -av;
        lo    = smin(av, bv);
        hi    = smax(av, bv);
        any_z = (av == 4'sd0) || (bv == 4'sd0);
        luk   = smin(4'sd1, 4'sd1 - av + bv);
        res   = 4'sd0;
        unique case (op_i)
            OP_NOT: res = (mode_i == ST_HEYTING) ?
                          ((av == -4'sd1) ? 4'sd1 : -4'sd1) : na;
            OP_AND: res = (mode_i == ST_BOCHVAR && any_z) ? 4'sd0 : lo;
            OP_OR:  res = (mode_i == ST_BOCHVAR && any_z) ? 4'sd0 : hi;
            OP_IMP: begin
                unique case (mode_i)
                    ST_LUKA:    res = luk;
                    ST_BOCHVAR: res = any_z ? 4'sd0 : smax(na, bv);
                    ST_HEYTING: res = (av <= bv) ? 4'sd1 : bv;
                    ST_RM3:     res = (av <= bv) ? smax(na, bv) : smin(na, bv);
                    default:    res = smax(na, bv);
                endcase
            end
        endcase
        y_o = trit_enc(res);
    end

    always_comb begin
        if (!$isunknown({mode_i, op_i, a_i, b_i})) begin
            // R1
            out_legal_chk: assert (y_o != 2'b10);
            // R6
            b3_infect_chk: assert (!(mode_i == ST_BOCHVAR && op_i != OP_NOT
                                    && (trit_val(a_i) == 4'sd0 || trit_val(b_i) == 4'sd0))
                                   || y_o == TR_Z);
            // R7
            heyt_not_chk: assert (!(mode_i == ST_HEYTING && op_i == OP_NOT) || y_o != TR_Z);
        end
    end

endmodule

// File: rtl/tern_logic_unit.sv
`timescale 1ns/1ps
module tern_logic_unit
    import tlu_pkg::*;
#(
    parameter int W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_wr_en,
    input  logic [2:0]     mode_code,
    input  logic [1:0]     op,
    input  logic [2*W-1:0] a,
    input  logic [2*W-1:0] b,
    output logic [2*W-1:0] y
);

    localparam int BITS = 2 * W;

    lmode_t mode_q;
    lop_t   op_e;

    assign op_e = lop_t'(op);

    tlu_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr_en),
        .code_in (mode_code),
        .mode_q  (mode_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_lane
        tlu_trit_cell u_cell (
            .mode_i (mode_q),
            .op_i   (op_e),
            .a_i    (a[2*i +: 2]),
            .b_i    (b[2*i +: 2]),
            .y_o    (y[2*i +: 2])
        );
    end

    // R2
    lane_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_NOT && $stable(a) && $stable(mode_q) && $stable(op_e)) |-> $stable(y));

    if (BITS < 2) begin : g_bad
        initial $error("W must be at least 1");
    end

endmodule

// File: tb/tern_logic_unit_tb.sv
`timescale 1ns/1ps
module tern_logic_unit_tb;

    localparam int W = 4;
    localparam logic [1:0] P = 2'b01, Z = 2'b00, N = 2'b11;

    // {mode[28:26], op[25:24], a[23:16], b[15:8], expected[7:0]}, lane 3 leftmost
    localparam int NV = 11;
    localparam logic [28:0] VEC [NV] = '{
        {3'd0, 2'd3, {P,Z,N,P}, {Z,Z,P,N}, {Z,Z,P,N}},  // R4
        {3'd1, 2'd3, {P,Z,N,P}, {Z,Z,P,N}, {Z,P,P,N}},  // R5
        {3'd2, 2'd1, {Z,P,N,P}, {P,P,Z,N}, {Z,P,Z,N}},  // R6
        {3'd2, 2'd2, {Z,P,N,P}, {P,P,Z,N}, {Z,P,Z,P}},  // R6
        {3'd3, 2'd0, {P,Z,N,Z}, {Z,Z,Z,Z}, {N,N,P,N}},  // R7
        {3'd3, 2'd3, {Z,P,N,Z}, {N,Z,Z,Z}, {N,Z,P,P}},  // R7
        {3'd4, 2'd3, {Z,P,N,P}, {Z,N,P,P}, {Z,N,P,P}},  // R8
        {3'd0, 2'd1, {P,Z,N,P}, {N,P,Z,P}, {N,Z,N,P}},  // R3
        {3'd4, 2'd2, {P,Z,N,P}, {N,P,Z,P}, {P,P,Z,P}},  // R3
        {3'd6, 2'd3, {Z,Z,P,N}, {Z,Z,Z,Z}, {Z,Z,Z,P}},  // R10
        {3'd2, 2'd3, {Z,P,P,N}, {P,N,P,Z}, {Z,N,P,Z}}   // R6
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mode_wr_en = 1'b0;
    logic [2:0]     mode_code = 3'd0;
    logic [1:0]     op = 2'd0;
    logic [2*W-1:0] a = '0;
    logic [2*W-1:0] b = '0;
    logic [2*W-1:0] y;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tern_logic_unit #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .mode_code(mode_code),
        .op(op), .a(a), .b(b), .y(y)
    );

    function automatic int tv(input logic [1:0] t);
        return (t == P) ? 1 : (t == N) ? -1 : 0;
    endfunction

    function automatic logic [1:0] te(input int v);
        return (v > 0) ? P : (v < 0) ? N : Z;
    endfunction

    // bench model of the truth tables, taken from the requirements
    function automatic int model(input int m, input int o, input int x, input int w);
        int mn = (x < w) ? x : w;
        int mx = (x > w) ? x : w;
        int nx = -x;
        bit zz = (x == 0) || (w == 0);
        if (m > 4) m = 0;
        case (o)
            0: return (m == 3) ? ((x == -1) ? 1 : -1) : nx;
            1: return (m == 2 && zz) ? 0 : mn;
            2: return (m == 2 && zz) ? 0 : mx;
            default: begin
                case (m)
                    1: return (1 - x + w > 1) ? 1 : 1 - x + w;
                    2: return zz ? 0 : ((nx > w) ? nx : w);
                    3: return (x <= w) ? 1 : w;
                    4: return (x <= w) ? ((nx > w) ? nx : w) : ((nx < w) ? nx : w);
                    default: return (nx > w) ? nx : w;
                endcase
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [2*W-1:0] exp);
        #1;
        n_vec++;
        if (y !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, y, exp);
        end
    endtask

    task automatic load_mode(input logic [2:0] code);
        @(negedge clk);
        mode_code  = code;
        mode_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mode_wr_en = 1'b0;
    endtask

    task automatic apply(input logic [1:0] o, input logic [2*W-1:0] xa,
                         input logic [2*W-1:0] xb);
        @(negedge clk);
        op = o; a = xa; b = xb;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R11 reset state: Kleene IMPLY(Z,Z) = Z; a write during reset is ignored
        mode_code = 3'd1; mode_wr_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); mode_wr_en = 1'b0; rst_n = 1'b1;
        apply(2'd3, {W{Z}}, {W{Z}});
        check("R11 reset mode", {W{Z}});

        // table walk
        for (int i = 0; i < NV; i++) begin
            load_mode(VEC[i][28:26]);
            apply(VEC[i][25:24], VEC[i][23:16], VEC[i][15:8]);
            check("R3-R10 table", VEC[i][7:0]);
        end

        // exhaustive nine pairs per operator per mode (R3 R4 R5 R6 R7 R8 R9)
        for (int m = 0; m < 5; m++) begin
            load_mode(3'(m));
            for (int o = 0; o < 4; o++)
                for (int x = -1; x <= 1; x++)
                    for (int w = -1; w <= 1; w++) begin
                        apply(2'(o), {W{te(x)}}, {W{te(w)}});
                        check("R9 truth table", {W{te(model(m, o, x, w))}});
                    end
        end

        // R1 unused code 2'b10 reads as Z
        load_mode(3'd0);
        apply(2'd1, {W{2'b10}}, {W{P}});
        check("R1 invalid code AND", {W{Z}});
        apply(2'd0, {W{2'b10}}, {W{N}});
        check("R1 invalid code NOT", {W{Z}});

        // R2 NOT ignores b; lanes independent
        apply(2'd0, {P,N,Z,P}, {N,N,N,N});
        check("R2 NOT ignores b", {N,P,Z,N});
        apply(2'd0, {P,N,Z,P}, {P,Z,P,Z});
        check("R2 NOT ignores b", {N,P,Z,N});

        // R12 hold: mode_code changes without enable
        @(negedge clk); mode_code = 3'd1;
        repeat (2) @(posedge clk);
        apply(2'd3, {W{Z}}, {W{Z}});
        check("R12 hold", {W{Z}});

        // R11 reset returns Luk mode to Kleene
        load_mode(3'd1);
        apply(2'd3, {W{Z}}, {W{Z}});
        check("R5 luk before reset", {W{P}});
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        apply(2'd3, {W{Z}}, {W{Z}});
        check("R11 reset to Kleene", {W{Z}});

        // R10 code 7 falls back from Heyting
        load_mode(3'd3);
        load_mode(3'd7);
        apply(2'd0, {W{Z}}, {W{Z}});
        check("R10 fallback NOT", {W{Z}});

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule